// File: doc/BRIEF.md
# Dual 8-bit Toggle/PWM Timer

This block holds two 8-bit counter halves that share one cycle-clock enable. The mode field chooses how they work together. In mode 0 the halves are independent interval timers, and each one toggles its own output pin. In mode 1 they are independent free-running PWM generators. In mode 2 the high half counts the period matches of the low half, which forms a cascaded 16-bit toggle timer; the low half keeps its own toggle output. Mode 3 is also a cascade, but the low half runs as a free-running PWM and the high half counts its wraps and toggles the high pin.

Software programs the block through a write-only bus with a 2-bit address. There is a control register with the run bits and the mode, one value register per half, and a write-one-to-clear register for the two event flags. Each half raises its own flag when it reaches its terminal count, and one combined interrupt line is the OR of the two flags. Every port is a plain control or status pin. The block has no streaming interface, so it has no back-pressure rule.

Top module: `dual_pwm_timer`

## Requirements
- R1: While reset is held and after it is released, out_lo, out_hi, flag_lo, flag_hi and irq are all 0.
- R2: In mode 0, a running half counts up from 0 on each cycle with tick_en high. When its count equals its value register it returns to 0 and inverts its output, so each output first rises value+1 ticks after start and then toggles every value+1 ticks. The two halves are timed independently.
- R3: In mode 1, each running half counts freely from 0 to 255 and wraps back to 0. Its output is 1 while the count is below its duty in use, which gives a period of 256 ticks. A duty of 0 keeps the output at 0, and a duty of 255 drops it for one tick per period. out_lo uses the low value register and out_hi uses the high value register.
- R4: When a duty is written while a PWM half is running, it takes effect only at the tick where that half wraps from 255 to 0. A stopped half picks up its value register directly.
- R5: In mode 2, the low half behaves as in R2. The high half advances once per low-half match, so out_hi toggles every (low value+1)×(high value+1) ticks.
- R6: In mode 3, the low half is a PWM as in R3. The high half advances once per low-half wrap, so out_hi toggles every 256×(high value+1) ticks.
- R7: When a half's run bit is 0, its count is forced to 0 and its output is 0 from the next cycle. A later start restarts its timing from a count of 0 and a low toggle level.
- R8: While tick_en is 0, no count, output or flag changes, except through a bus write. The timing then resumes where it stopped, shifted by the number of missing ticks.
- R9: A half's flag sets at the tick of its event: a toggle match, a PWM wrap, or a cascade match. irq is 1 whenever either flag is 1. Writing address 3 clears flag_lo where data bit 0 is 1 and flag_hi where data bit 1 is 1. A 0 bit leaves its flag as it is.
- R10: Bus map. Address 0 is control: bit 0 runs the low half, bit 1 runs the high half, and bits 3:2 select the mode. Address 1 is the low value register and address 2 is the high value register. In modes 2 and 3, the high half needs both run bits set to advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Cycle-clock enable for the counters |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Bus write address |
| wr_data | input | 8 | Bus write data |
| out_lo | output | 1 | Low output pin (toggle or PWM) |
| out_hi | output | 1 | High output pin (toggle or PWM) |
| irq | output | 1 | Combined interrupt request |
| flag_lo | output | 1 | Low-half event flag |
| flag_hi | output | 1 | High-half event flag |

## Verification
In mode 0 the two halves get unequal periods. This shows whether they are really independent and catches an off-by-one in the match point. A low-only restart after a stop separates "restart from zero" from "resume", and a six-tick gap in tick_en shows whether ticks are truly skipped rather than lost or doubled. The PWM runs use duties of 0, 64 and 255, together with a duty rewrite in the middle of a period. These tell apart the strict below-duty compare, the all-low case, the one-tick-low case and deferred loading. The cascade runs with small values confirm that the high half counts low matches in mode 2 and low wraps in mode 3.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
  typedef enum logic [1:0] {
    MODE_SPLIT_TOGGLE = 2'd0,
    MODE_SPLIT_PWM    = 2'd1,
    MODE_CASC_TOGGLE  = 2'd2,
    MODE_CASC_PWM     = 2'd3
  } ptt_mode_e;

  localparam logic [1:0] ADDR_CTRL     = 2'd0;
  localparam logic [1:0] ADDR_VAL_LO   = 2'd1;
  localparam logic [1:0] ADDR_VAL_HI   = 2'd2;
  localparam logic [1:0] ADDR_FLAG_CLR = 2'd3;

  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/ptt_regs.sv
module ptt_regs
  import ptt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [CW-1:0]         wr_data,
  output logic [NUM_HALVES-1:0] run,
  output ptt_mode_e             mode,
  output logic [CW-1:0]         val_lo,
  output logic [CW-1:0]         val_hi,
  output logic [NUM_HALVES-1:0] clr_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= '0;
      mode   <= MODE_SPLIT_TOGGLE;
      val_lo <= '0;
      val_hi <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          run  <= wr_data[1:0];
          mode <= ptt_mode_e'(wr_data[3:2]);
        end
        ADDR_VAL_LO: val_lo <= wr_data;
        ADDR_VAL_HI: val_hi <= wr_data;
        default: ;
      endcase
    end
  end

  // write-one-to-clear request, one bit per half
  always_comb begin
    clr_req = '0;
    if (wr_en && wr_addr == ADDR_FLAG_CLR) clr_req = wr_data[NUM_HALVES-1:0];
  end
endmodule

// File: rtl/ptt_half.sv
module ptt_half #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic          pwm_sel,
  input  logic [CW-1:0] value,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] shadow,
  output logic          term,
  output logic          evt,
  output logic          tog,
  output logic          level
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  // terminal count: wrap point in PWM, period match otherwise
  assign term  = pwm_sel ? (cnt == CNT_TOP) : (cnt == value);
  assign evt   = run && step && term;
  assign level = run && (cnt < shadow);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      shadow <= '0;
      tog    <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      tog    <= 1'b0;
      shadow <= value;
    end else if (step) begin
      if (pwm_sel) begin
        cnt <= cnt + 1'b1;
        if (term) shadow <= value;
      end else if (term) begin
        cnt <= '0;
        tog <= ~tog;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ptt_flags.sv
module ptt_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flags
);
  // a same-cycle event wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_req) | set_evt;
  end
endmodule

// File: rtl/dual_pwm_timer.sv
module dual_pwm_timer
  import ptt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          out_lo,
  output logic          out_hi,
  output logic          irq,
  output logic          flag_lo,
  output logic          flag_hi
);
  logic [NUM_HALVES-1:0] run, step, pwm_sel, term, evt, tog, lvl, pin, clr_req, flags;
  logic [CW-1:0]         val    [NUM_HALVES];
  logic [CW-1:0]         cnt    [NUM_HALVES];
  logic [CW-1:0]         shadow [NUM_HALVES];
  ptt_mode_e             mode;
  logic                  cascade;

  ptt_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .mode(mode), .val_lo(val[0]), .val_hi(val[1]), .clr_req(clr_req)
  );

  assign cascade = (mode == MODE_CASC_TOGGLE) || (mode == MODE_CASC_PWM);

  always_comb begin
    pwm_sel[0] = (mode == MODE_SPLIT_PWM) || (mode == MODE_CASC_PWM);
    pwm_sel[1] = (mode == MODE_SPLIT_PWM);
    step[0]    = tick_en;
    step[1]    = cascade ? (tick_en && run[0] && term[0]) : tick_en;
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ptt_half #(.CW(CW)) u_half (
      .clk(clk), .rst_n(rst_n), .run(run[h]), .step(step[h]), .pwm_sel(pwm_sel[h]),
      .value(val[h]), .cnt(cnt[h]), .shadow(shadow[h]), .term(term[h]), .evt(evt[h]),
      .tog(tog[h]), .level(lvl[h])
    );
    assign pin[h] = pwm_sel[h] ? lvl[h] : tog[h];
  end

  ptt_flags #(.N(NUM_HALVES)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(evt), .clr_req(clr_req), .flags(flags)
  );

  assign out_lo  = pin[0];
  assign out_hi  = pin[1];
  assign flag_lo = flags[0];
  assign flag_hi = flags[1];
  assign irq     = |flags;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic [CW-1:0] wr_data,
  input logic          out_lo,
  input logic          out_hi,
  input logic          flag_lo,
  input logic          flag_hi,
  input logic [1:0]    run,
  input logic          pwm_sel_lo,
  input logic [CW-1:0] cnt_lo,
  input logic [CW-1:0] cnt_hi,
  input logic [CW-1:0] shadow_lo,
  input logic [CW-1:0] shadow_hi
);
  a_r8_outputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en && run == $past(run)) |=> ($stable(out_lo) && $stable(out_hi)));

  a_r8_flags_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_en) |=> ($stable(flag_lo) && $stable(flag_hi)));

  a_r9_clear_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[0] && !tick_en) |=> !flag_lo);

  a_r9_clear_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3 && wr_data[1] && !tick_en) |=> !flag_hi);

  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_sel_lo && shadow_lo == '0) |-> !out_lo);

  a_r4_shadow_lo_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shadow_lo) |-> (!$past(run[0]) || $past(cnt_lo) == '1));

  a_r4_shadow_hi_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shadow_hi) |-> (!$past(run[1]) || $past(cnt_hi) == '1));

  a_r7_stopped_lo_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[0] && !$past(run[0])) |-> !out_lo);

  a_r7_stopped_hi_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!run[1] && !$past(run[1])) |-> !out_hi);
endmodule

bind dual_pwm_timer ptt_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .out_lo(out_lo), .out_hi(out_hi), .flag_lo(flag_lo),
  .flag_hi(flag_hi), .run(run), .pwm_sel_lo(pwm_sel[0]), .cnt_lo(cnt[0]),
  .cnt_hi(cnt[1]), .shadow_lo(shadow[0]), .shadow_hi(shadow[1])
);

// File: tb/dual_pwm_timer_test.sv
`timescale 1ns/1ps
module dual_pwm_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       out_lo, out_hi, irq, flag_lo, flag_hi;

  dual_pwm_timer #(.CW(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_lo(out_lo), .out_hi(out_hi), .irq(irq),
    .flag_lo(flag_lo), .flag_hi(flag_hi)
  );

  always #10 clk = ~clk;

  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 0;
  bit    done = 0;
  string cur_req = "";
  int    qlo[$];
  int    qhi[$];
  logic  prev_lo = 1'b0;
  logic  prev_hi = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard compare: items are cycle*2+level
  task automatic pop_cmp(ref int q[$], input string pin, input logic lvl);
    if (q.size() == 0) begin
      check(1'b0, cur_req, {pin, " unexpected edge (cycle*2+level)"}, cyc*2 + int'(lvl), -1);
    end else begin
      int e = q.pop_front();
      check(e == cyc*2 + int'(lvl), cur_req, {pin, " edge (cycle*2+level)"},
            cyc*2 + int'(lvl), e);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_lo !== prev_lo) pop_cmp(qlo, "out_lo", out_lo);
      if (out_hi !== prev_hi) pop_cmp(qhi, "out_hi", out_hi);
    end
    prev_lo = out_lo;
    prev_hi = out_hi;
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    at = cyc;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic push_toggle(ref int q[$], input int w, input int per, input int len);
    for (int k = 1; k * per < len; k++) q.push_back((w + k*per)*2 + (k % 2));
  endtask

  task automatic push_pwm(ref int q[$], input int w, input int duty, input int len);
    for (int p = 0; p*256 < len; p++) begin
      if (duty > 0) begin
        q.push_back((w + p*256)*2 + 1);
        if (p*256 + duty < len) q.push_back((w + p*256 + duty)*2);
      end
    end
  endtask

  task automatic close_window(input string req);
    mon_on = 0;
    check(qlo.size() == 0, req, "missing out_lo edges", qlo.size(), 0);
    check(qhi.size() == 0, req, "missing out_hi edges", qhi.size(), 0);
    qlo.delete();
    qhi.delete();
  endtask

  task automatic stop_all(input string req);
    int t;
    bus_wr(2'd0, 8'h00, t);
    repeat (2) @(posedge clk);
    #1;
    check(out_lo == 1'b0, req, "out_lo after stop", out_lo, 0);
    check(out_hi == 1'b0, req, "out_hi after stop", out_hi, 0);
  endtask

  initial begin
    int w, t;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state while held and after release
    check({out_lo, out_hi, irq, flag_lo, flag_hi} == 5'b0, "R1", "outputs in reset",
          {out_lo, out_hi, irq, flag_lo, flag_hi}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check({out_lo, out_hi, irq, flag_lo, flag_hi} == 5'b0, "R1", "outputs after reset",
          {out_lo, out_hi, irq, flag_lo, flag_hi}, 0);

    // R2: mode 0, unequal periods
    bus_wr(2'd1, 8'd4, t);
    bus_wr(2'd2, 8'd9, t);
    cur_req = "R2"; mon_on = 1;
    bus_wr(2'd0, 8'h03, w);
    push_toggle(qlo, w, 5, 60);
    push_toggle(qhi, w, 10, 60);
    wait_until(w + 60);
    close_window("R2");
    stop_all("R7");
    // R9 flags and clearing
    check(flag_lo && flag_hi && irq, "R9", "flags after mode 0 run", {flag_lo, flag_hi, irq}, 7);
    bus_wr(2'd3, 8'h00, t);
    #2;
    check(flag_lo && flag_hi, "R9", "zero clear has no effect", {flag_lo, flag_hi}, 3);
    bus_wr(2'd3, 8'h01, t);
    #2;
    check(!flag_lo && flag_hi && irq, "R9", "clear low flag", {flag_lo, flag_hi, irq}, 3);
    bus_wr(2'd3, 8'h02, t);
    #2;
    check(!flag_lo && !flag_hi && !irq, "R9", "clear high flag", {flag_lo, flag_hi, irq}, 0);

    // R7 restart from zero, R10 low run bit only
    bus_wr(2'd1, 8'd2, t);
    cur_req = "R7/R10"; mon_on = 1;
    bus_wr(2'd0, 8'h01, w);
    push_toggle(qlo, w, 3, 20);
    wait_until(w + 20);
    close_window("R7/R10");
    stop_all("R7");
    bus_wr(2'd3, 8'h03, t);

    // R8 tick gap of six cycles
    bus_wr(2'd1, 8'd3, t);
    cur_req = "R8"; mon_on = 1;
    bus_wr(2'd0, 8'h01, w);
    qlo.push_back((w + 4)*2 + 1);
    for (int k = 2; 4*k + 6 < 40; k++) qlo.push_back((w + 4*k + 6)*2 + (k % 2));
    wait_until(w + 5);
    tick_en = 1'b0;
    wait_until(w + 9);
    check(out_lo == 1'b1, "R8", "out_lo held during gap", out_lo, 1);
    wait_until(w + 11);
    tick_en = 1'b1;
    wait_until(w + 40);
    close_window("R8");
    stop_all("R7");
    bus_wr(2'd3, 8'h03, t);

    // R3 mode 1: duty 64 low, duty 0 high
    bus_wr(2'd1, 8'd64, t);
    bus_wr(2'd2, 8'd0, t);
    cur_req = "R3"; mon_on = 1;
    bus_wr(2'd0, 8'h07, w);
    push_pwm(qlo, w, 64, 530);
    wait_until(w + 255);
    check(flag_lo == 1'b0, "R9", "flag_lo before first wrap", flag_lo, 0);
    wait_until(w + 256);
    check(flag_lo == 1'b1, "R9", "flag_lo at first wrap", flag_lo, 1);
    wait_until(w + 530);
    close_window("R3");
    check(flag_hi == 1'b1, "R9", "flag_hi from zero-duty wrap", flag_hi, 1);
    stop_all("R7");
    bus_wr(2'd3, 8'h03, t);

    // R4 mid-period duty rewrite, R3 duty 255
    bus_wr(2'd1, 8'd100, t);
    bus_wr(2'd2, 8'd255, t);
    cur_req = "R4"; mon_on = 1;
    bus_wr(2'd0, 8'h07, w);
    qlo.push_back(w*2 + 1);
    qlo.push_back((w + 100)*2);
    qlo.push_back((w + 256)*2 + 1);
    qlo.push_back((w + 286)*2);
    qlo.push_back((w + 512)*2 + 1);
    push_pwm(qhi, w, 255, 520);
    wait_until(w + 20);
    bus_wr(2'd1, 8'd30, t);
    wait_until(w + 520);
    close_window("R4");
    stop_all("R7");
    bus_wr(2'd3, 8'h03, t);

    // R5 mode 2 cascade
    bus_wr(2'd1, 8'd2, t);
    bus_wr(2'd2, 8'd3, t);
    cur_req = "R5"; mon_on = 1;
    bus_wr(2'd0, 8'h0B, w);
    push_toggle(qlo, w, 3, 60);
    push_toggle(qhi, w, 12, 60);
    wait_until(w + 60);
    close_window("R5");
    stop_all("R7");
    bus_wr(2'd3, 8'h03, t);

    // R6 mode 3: low PWM 200, high toggles every 512
    bus_wr(2'd1, 8'd200, t);
    bus_wr(2'd2, 8'd1, t);
    cur_req = "R6"; mon_on = 1;
    bus_wr(2'd0, 8'h0F, w);
    push_pwm(qlo, w, 200, 1030);
    push_toggle(qhi, w, 512, 1030);
    wait_until(w + 1030);
    close_window("R6");
    stop_all("R7");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1..): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule